// File: doc/BRIEF.md
# SAR Conversion Sequencer with Dither

This block is the digital controller for the 9-bit successive-approximation first stage of a two-stage capacitance digitizer. It runs a fixed frame of three phases. In the sense phase, the sensor is charged from the reference, or from an external test voltage, while every DAC bottom plate is held at reset and the top plate sits at common mode. In the search phase, the offset capacitor is high and the sensor plate is low, and the code is resolved MSB first from a single comparator decision bit. In the residue phase, the final code stays on the DAC so that a time-domain quantizer can integrate what is left.

After the search ends, one extra dither capacitor is switched high for the residue phase when the frame's pseudorandom bit is 1. That bit comes from a 20-bit maximal-length shift register that steps once per frame. The resolved code and the dither bit are presented together with a one-cycle done strobe at the boundary between the search and residue phases. They stay unchanged until the next strobe, so a downstream gain estimator can pair each quantizer result with its dither bit.

With a 250 MHz clock, the default frame has 83 cycles (about 332 ns): 68 sense cycles, 9 search cycles and 6 residue cycles (about 24 ns).

Top module: `sar_conv_seq`

## Requirements
- R1: Each frame lasts 83 cycles with the phases in a fixed order: sense for 68 cycles, search for 9, residue for 6. Exactly one of `sense_ph_o`, `search_ph_o`, `resid_ph_o` is high in every cycle, and the block is in the sense phase during and right after reset.
- R2: During the sense phase `dac_sw_o` is all zero, `top_cm_o` is 1 and `offset_hi_o` is 0.
- R3: During the search and residue phases `top_cm_o` is 0, `offset_hi_o` is 1, and both `sense_ref_o` and `sense_ext_o` are 0.
- R4: In search cycle k (k = 0..8), `dac_sw_o` equals the bits already kept above position 8-k, with bit 8-k also set. `cmp_i` is sampled at the end of that cycle: 1 keeps the bit, 0 drops it.
- R5: With an ideal comparator (`cmp_i` = 1 when the target is at least the DAC value), `code_o` equals the target clamped to 0..511. `code_o` and `dither_o` change only together with `done_o`; after reset both are 0.
- R6: `done_o` is a one-cycle pulse in the first residue cycle of every frame and is 0 in all other cycles.
- R7: `dith_sw_o` is 0 in the sense and search phases. During the residue phase it equals the frame's dither bit.
- R8: The dither bit is bit 0 of a 20-bit register. The register is seeded to 1 by reset and shifts toward bit 19 at the last cycle of each frame, with bit 19 XOR bit 16 entering at bit 0. The first frame after reset therefore has dither 1, and `dither_o` reports that frame's bit at its done strobe.
- R9: `mode_i` is sampled on the last cycle of each frame and applies to the next frame; reset selects normal mode. In the sense phase, normal mode (1) drives `sense_ref_o` high, and test mode (0) drives `sense_ext_o` high instead.
- R10: During the residue phase `dac_sw_o` holds the final code, equal to `code_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 1 | 1 normal (reference), 0 test (external voltage), applied from next frame |
| cmp_i | input | 1 | Comparator decision, 1 keeps the trial bit |
| sense_ph_o | output | 1 | Sense phase strobe |
| search_ph_o | output | 1 | Search phase strobe |
| resid_ph_o | output | 1 | Residue phase strobe |
| top_cm_o | output | 1 | Top plate tied to common mode |
| sense_ref_o | output | 1 | Sensor plate to reference (normal mode, sense phase) |
| sense_ext_o | output | 1 | Sensor plate to external input (test mode, sense phase) |
| offset_hi_o | output | 1 | Offset capacitor driven high |
| dac_sw_o | output | 9 | DAC bottom-plate controls, 1 = high |
| dith_sw_o | output | 1 | Dither capacitor driven high |
| code_o | output | 9 | Resolved first-stage code |
| dither_o | output | 1 | Dither bit belonging to `code_o` |
| done_o | output | 1 | One-cycle strobe, code and dither valid |

## Verification
The assertions check on every cycle that exactly one phase strobe is active, how the plates are driven in each phase, that the first search cycle presents only the MSB trial, that the done pulse falls on the search-to-residue boundary, that the code and dither outputs stay unchanged between strobes, and that the dither capacitor is driven only during the residue phase. Only the bench scenarios can show that each search step is right for a given target, that codes clamp at both ends, that the dither sequence follows the shift-register rule over many frames, and that a mode change takes effect exactly one frame later.

// File: rtl/sar_seq_pkg.sv
// Package: shared phase type and default sizes for the SAR conversion sequencer.
// Assumes: one frame consists of the sense, search and residue phases in that order.
package sar_seq_pkg;

    localparam int SEQ_SAR_BITS  = 9;
    localparam int SEQ_FRAME_CYC = 83;
    localparam int SEQ_RESID_CYC = 6;
    localparam int SEQ_LFSR_LEN  = 20;

    typedef enum logic [1:0] {
        PH_SENSE  = 2'd0,
        PH_SEARCH = 2'd1,
        PH_RESID  = 2'd2
    } phase_e;

endpackage

// File: rtl/sar_frame_timer.sv
// Module: sar_frame_timer
// Counts the cycles of one conversion frame and decodes the phase, the index of the
// bit under trial, the last search cycle and the last cycle of the frame.
// Assumes: FRAME_CYC > SAR_BITS + RESID_CYC, so the sense phase is at least one cycle.
module sar_frame_timer
    import sar_seq_pkg::*;
#(
    parameter int FRAME_CYC = SEQ_FRAME_CYC,
    parameter int SAR_BITS  = SEQ_SAR_BITS,
    parameter int RESID_CYC = SEQ_RESID_CYC,
    localparam int IW       = (SAR_BITS > 1) ? $clog2(SAR_BITS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    output phase_e        phase_o,
    output logic [IW-1:0] bit_idx_o,
    output logic          last_search_o,
    output logic          frame_end_o
);
    localparam int SENSE_CYC = FRAME_CYC - SAR_BITS - RESID_CYC;
    localparam int CW        = $clog2(FRAME_CYC);
    localparam logic [CW-1:0] SRCH_START = CW'(SENSE_CYC);
    localparam logic [CW-1:0] RES_START  = CW'(SENSE_CYC + SAR_BITS);
    localparam logic [CW-1:0] SRCH_LAST  = CW'(SENSE_CYC + SAR_BITS - 1);
    localparam logic [CW-1:0] LAST_CYC   = CW'(FRAME_CYC - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] offs;
    logic          in_search;

    // Frame cycle counter, wraps after the last residue cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q == LAST_CYC)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // Phase decode from the counter.
    always_comb begin
        if (cnt_q < SRCH_START)
            phase_o = PH_SENSE;
        else if (cnt_q < RES_START)
            phase_o = PH_SEARCH;
        else
            phase_o = PH_RESID;
    end

    assign in_search = (phase_o == PH_SEARCH);
    assign offs      = cnt_q - SRCH_START;

    // Trial bit index, MSB first.
    always_comb begin
        if (in_search)
            bit_idx_o = IW'(SAR_BITS - 1) - offs[IW-1:0];
        else
            bit_idx_o = '0;
    end

    assign last_search_o = (cnt_q == SRCH_LAST);
    assign frame_end_o   = (cnt_q == LAST_CYC);

endmodule

// File: rtl/sar_bit_search.sv
// Module: sar_bit_search
// Successive-approximation register: sets one trial bit per search cycle, keeps it
// when the comparator says so, drives the bottom-plate controls, and publishes the
// final code with a one-cycle done pulse.
// Assumes: cmp_i is settled for the DAC value presented in the same cycle.
module sar_bit_search
    import sar_seq_pkg::*;
#(
    parameter int SAR_BITS = SEQ_SAR_BITS,
    localparam int IW      = (SAR_BITS > 1) ? $clog2(SAR_BITS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  phase_e              phase_i,
    input  logic [IW-1:0]       bit_idx_i,
    input  logic                last_search_i,
    input  logic                cmp_i,
    output logic [SAR_BITS-1:0] dac_sw_o,
    output logic [SAR_BITS-1:0] code_o,
    output logic                done_o
);
    logic [SAR_BITS-1:0] trial;
    logic [SAR_BITS-1:0] kept;
    logic [SAR_BITS-1:0] code_q;
    logic [SAR_BITS-1:0] code_out_q;
    logic                done_q;

    // One-hot decoder for the bit under trial.
    for (genvar g = 0; g < SAR_BITS; g++) begin : g_trial
        assign trial[g] = (bit_idx_i == IW'(g));
    end

    assign kept = cmp_i ? trial : '0;

    // Decided bits: cleared while sensing, accumulated while searching.
    always_ff @(posedge clk) begin
        if (!rst_n)
            code_q <= '0;
        else if (phase_i == PH_SENSE)
            code_q <= '0;
        else if (phase_i == PH_SEARCH)
            code_q <= code_q | kept;
    end

    // Publish the final code and the done pulse at the end of the search.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_out_q <= '0;
            done_q     <= 1'b0;
        end else begin
            done_q <= last_search_i;
            if (last_search_i)
                code_out_q <= code_q | kept;
        end
    end

    // Bottom-plate drive per phase.
    always_comb begin
        case (phase_i)
            PH_SEARCH: dac_sw_o = code_q | trial;
            PH_RESID:  dac_sw_o = code_q;
            default:   dac_sw_o = '0;
        endcase
    end

    assign code_o = code_out_q;
    assign done_o = done_q;

endmodule

// File: rtl/sar_dither_lfsr.sv
// Module: sar_dither_lfsr
// Fibonacci shift register for the dither bit; steps once per step_i pulse.
// Assumes: the seed is nonzero and the taps give a maximal-length sequence.
module sar_dither_lfsr #(
    parameter int          LEN    = 20,
    parameter int          TAP_HI = 19,
    parameter int          TAP_LO = 16,
    parameter int unsigned SEED   = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    output logic bit_o
);
    logic [LEN-1:0] state_q;
    logic           fb;

    assign fb = state_q[TAP_HI] ^ state_q[TAP_LO];

    // Shift toward the MSB with feedback entering at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= LEN'(SEED);
        else if (step_i)
            state_q <= {state_q[LEN-2:0], fb};
    end

    assign bit_o = state_q[0];

endmodule

// File: rtl/sar_conv_seq.sv
// Module: sar_conv_seq (top)
// Frame sequencer for a SAR first stage: phase strobes, sensor/offset/top-plate
// controls, MSB-first search, and a dither capacitor switched only in the residue phase.
// Assumes: mode_i changes take effect from the frame after they are sampled.
module sar_conv_seq
    import sar_seq_pkg::*;
#(
    parameter int FRAME_CYC = SEQ_FRAME_CYC,
    parameter int SAR_BITS  = SEQ_SAR_BITS,
    parameter int RESID_CYC = SEQ_RESID_CYC,
    parameter int LFSR_LEN  = SEQ_LFSR_LEN
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_i,
    input  logic                cmp_i,
    output logic                sense_ph_o,
    output logic                search_ph_o,
    output logic                resid_ph_o,
    output logic                top_cm_o,
    output logic                sense_ref_o,
    output logic                sense_ext_o,
    output logic                offset_hi_o,
    output logic [SAR_BITS-1:0] dac_sw_o,
    output logic                dith_sw_o,
    output logic [SAR_BITS-1:0] code_o,
    output logic                dither_o,
    output logic                done_o
);
    localparam int IW = (SAR_BITS > 1) ? $clog2(SAR_BITS) : 1;

    phase_e        phase;
    logic [IW-1:0] bit_idx;
    logic          last_search;
    logic          frame_end;
    logic          lfsr_bit;
    logic          mode_q;
    logic          dither_q;

    sar_frame_timer #(
        .FRAME_CYC(FRAME_CYC),
        .SAR_BITS (SAR_BITS),
        .RESID_CYC(RESID_CYC)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .phase_o      (phase),
        .bit_idx_o    (bit_idx),
        .last_search_o(last_search),
        .frame_end_o  (frame_end)
    );

    sar_bit_search #(
        .SAR_BITS(SAR_BITS)
    ) u_search (
        .clk          (clk),
        .rst_n        (rst_n),
        .phase_i      (phase),
        .bit_idx_i    (bit_idx),
        .last_search_i(last_search),
        .cmp_i        (cmp_i),
        .dac_sw_o     (dac_sw_o),
        .code_o       (code_o),
        .done_o       (done_o)
    );

    sar_dither_lfsr #(
        .LEN   (LFSR_LEN),
        .TAP_HI(LFSR_LEN - 1),
        .TAP_LO(LFSR_LEN - 4),
        .SEED  (1)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step_i(frame_end),
        .bit_o (lfsr_bit)
    );

    // Mode latch: sampled on the last cycle of a frame, normal after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= 1'b1;
        else if (frame_end)
            mode_q <= mode_i;
    end

    // Capture the frame's dither bit alongside the code.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dither_q <= 1'b0;
        else if (last_search)
            dither_q <= lfsr_bit;
    end

    assign sense_ph_o  = (phase == PH_SENSE);
    assign search_ph_o = (phase == PH_SEARCH);
    assign resid_ph_o  = (phase == PH_RESID);
    assign top_cm_o    = sense_ph_o;
    assign offset_hi_o = !sense_ph_o;
    assign sense_ref_o = sense_ph_o && mode_q;
    assign sense_ext_o = sense_ph_o && !mode_q;
    assign dith_sw_o   = resid_ph_o && lfsr_bit;
    assign dither_o    = dither_q;

endmodule

// File: rtl/sar_conv_seq_chk.sv
// Module: sar_conv_seq_chk
// Property checker for sar_conv_seq, attached with bind below.
// Assumes: synchronous active-low reset; properties are disabled while it is low.
module sar_conv_seq_chk #(
    parameter int SAR_BITS = 9
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sense_ph_o,
    input logic                search_ph_o,
    input logic                resid_ph_o,
    input logic                top_cm_o,
    input logic                sense_ref_o,
    input logic                sense_ext_o,
    input logic                offset_hi_o,
    input logic [SAR_BITS-1:0] dac_sw_o,
    input logic                dith_sw_o,
    input logic [SAR_BITS-1:0] code_o,
    input logic                dither_o,
    input logic                done_o
);
    AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sense_ph_o, search_ph_o, resid_ph_o}) == 1); // R1

    AST_SENSE_PLATES: assert property (@(posedge clk) disable iff (!rst_n)
        sense_ph_o |-> (dac_sw_o == '0 && top_cm_o && !offset_hi_o)); // R2

    AST_SENSOR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !sense_ph_o |-> (!sense_ref_o && !sense_ext_o && offset_hi_o && !top_cm_o)); // R3

    AST_FIRST_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(search_ph_o) |-> dac_sw_o == {1'b1, {(SAR_BITS-1){1'b0}}}); // R4

    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(code_o) && $stable(dither_o))); // R5

    AST_DONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (resid_ph_o && $past(search_ph_o))); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6

    AST_DITHER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        dith_sw_o |-> resid_ph_o); // R7

    AST_DITHER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        resid_ph_o |-> (dith_sw_o == dither_o)); // R7

    AST_SENSE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        sense_ph_o |-> (sense_ref_o ^ sense_ext_o)); // R9

    AST_RESID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        resid_ph_o |-> (dac_sw_o == code_o)); // R10

endmodule

bind sar_conv_seq sar_conv_seq_chk #(.SAR_BITS(SAR_BITS)) u_chk (.*);

// File: tb/sar_conv_seq_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes the expected code and dither bit for each frame,
// and the monitor checks every cycle and pops the expectation at each done strobe.
module sar_conv_seq_tb_top;
    localparam int FRAME    = 83;
    localparam int SENSE    = 68;
    localparam int RES0     = 77;
    localparam int N_FRAMES = 44;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_i = 1'b1;
    logic       cmp_i;
    logic       sense_ph, search_ph, resid_ph, top_cm, sense_ref, sense_ext, offset_hi;
    logic [8:0] dac_sw, code;
    logic       dith_sw, dither, done;

    int target = 0;
    int dac_int;
    int n_chk = 0;
    int n_bad = 0;

    logic [9:0]  exp_q[$];
    int          cur_code = 0;
    bit          cur_dith = 0;
    int          last_code = 0;
    bit          last_dith = 0;
    bit          mode_exp = 1;
    int          fc = 0;
    logic [19:0] lfsr_m = 20'd1;

    always #2 clk = ~clk;

    // Ideal comparator on a numeric residue.
    assign dac_int = int'({23'd0, dac_sw});
    assign cmp_i   = (target >= dac_int);

    sar_conv_seq dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .cmp_i(cmp_i),
        .sense_ph_o(sense_ph), .search_ph_o(search_ph), .resid_ph_o(resid_ph),
        .top_cm_o(top_cm), .sense_ref_o(sense_ref), .sense_ext_o(sense_ext),
        .offset_hi_o(offset_hi), .dac_sw_o(dac_sw), .dith_sw_o(dith_sw),
        .code_o(code), .dither_o(dither), .done_o(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic int clampc(input int t);
        return (t < 0) ? 0 : ((t > 511) ? 511 : t);
    endfunction

    function automatic int pick(input int f);
        case (f)
            0: return 0;
            1: return 511;
            2: return 600;
            3: return 256;
            4: return 255;
            5: return 1;
            6: return 341;
            7: return 170;
            8: return -5;
            9: return 510;
            default: return (f * 97 + 13) % 600;
        endcase
    endfunction

    // Driver: one frame per iteration, inputs changed 1 ns after a rising edge.
    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(sense_ph && !search_ph && !resid_ph, "R1 reset phase", {sense_ph, search_ph, resid_ph}, 4);
        chk(dac_sw == 9'd0, "R2 reset plates", dac_sw, 0);
        chk(!done && code == 9'd0 && !dither, "R5 reset outputs", code, 0);
        chk(!dith_sw, "R7 reset dither switch", dith_sw, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        for (int f = 0; f < N_FRAMES; f++) begin
            logic [8:0] cc;
            target   = pick(f);
            mode_i   = (f >= 10 && f < 15) ? 1'b0 : 1'b1;
            cur_code = clampc(target);
            cur_dith = lfsr_m[0];
            cc       = cur_code[8:0];
            exp_q.push_back({cur_dith, cc});
            lfsr_m   = {lfsr_m[18:0], lfsr_m[19] ^ lfsr_m[16]};
            repeat (FRAME) @(posedge clk);
            #1;
        end
        chk(exp_q.size() == 0, "R6 every frame strobed", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Monitor: per-cycle checks against the bench frame position.
    always @(negedge clk) begin
        if (!rst_n) begin
            fc        = 0;
            mode_exp  = 1;
            last_code = 0;
            last_dith = 0;
        end else begin
            bit p1, p2, p3;
            p1 = (fc < SENSE);
            p2 = (fc >= SENSE) && (fc < RES0);
            p3 = (fc >= RES0);
            chk({sense_ph, search_ph, resid_ph} == {p1, p2, p3}, "R1 phase order",
                {sense_ph, search_ph, resid_ph}, {p1, p2, p3});
            if (p1) begin
                chk(dac_sw == 9'd0, "R2 plates reset", dac_sw, 0);
                chk(top_cm && !offset_hi, "R2 top/offset", {top_cm, offset_hi}, 2);
                chk(sense_ref == mode_exp && sense_ext == !mode_exp, "R9 sensor source",
                    {sense_ref, sense_ext}, {mode_exp, !mode_exp});
            end else begin
                chk(!top_cm && offset_hi && !sense_ref && !sense_ext, "R3 plates after sense",
                    {top_cm, offset_hi, sense_ref, sense_ext}, 4);
            end
            if (p2) begin
                int k, mask, e;
                k    = fc - SENSE;
                mask = 512 - (1 << (9 - k));
                e    = (cur_code & mask) | (1 << (8 - k));
                chk(dac_int == e, "R4 search step", dac_int, e);
            end
            if (p3)
                chk(dac_int == cur_code, "R10 residue hold", dac_int, cur_code);
            chk(dith_sw == (p3 ? cur_dith : 1'b0), "R7 dither switch", dith_sw, p3 ? cur_dith : 0);
            chk(done == (fc == RES0), "R6 done timing", done, fc == RES0);
            if (done) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected done", 1, 0);
                end else begin
                    logic [9:0] it;
                    it = exp_q.pop_front();
                    chk(code == it[8:0], "R5 code", code, it[8:0]);
                    chk(dither == it[9], "R8 dither bit", dither, it[9]);
                    last_code = int'(it[8:0]);
                    last_dith = it[9];
                end
            end else if (fc < RES0) begin
                chk(int'(code) == last_code && dither == last_dith, "R5 output hold",
                    code, last_code);
            end
            if (fc == FRAME - 1)
                mode_exp = mode_i;
            fc = (fc + 1) % FRAME;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 4);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule